// File: doc/BRIEF.md
# Hardware cursor overlay generator

This block lays a 32x32 two-plane cursor over a stream of 24-bit pixels that arrive in raster order, each with its x and y coordinate and a valid flag. For every pixel it decides, one cycle later, whether the base pixel passes through or is replaced by one of two overlay colors. The two overlay colors and the active line width are inputs. The palette and the display timing sit outside the block.

The cursor shape is held in two planes of 32 rows each, one 32-bit word per row. The visibility plane marks which cursor pixels are drawn. The color-pick plane chooses between the two overlay colors for each drawn pixel. A position register places the top-left corner of the cursor. A spare read/write register completes the register window. Each pixel is sorted into one of three classes: PIX_PASS, PIX_COLOR2 or PIX_COLOR3. A `unique case` on that class selects the registered output. The register interface has a one-cycle write and a read whose data is registered.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor x and y are both 0xF000, both planes and the spare register are zero, `pix_valid_o` is 0 and `reg_rdata` is 0.
- R2: `pix_valid_o` equals `pix_valid_i` of the previous cycle. `pix_data_o` carries the result for the pixel presented in that previous cycle.
- R3: A pixel whose visibility bit is 0, or which lies outside the cursor window, leaves as its base pixel unchanged (class PIX_PASS).
- R4: A pixel whose visibility bit is 1 leaves as `overlay_color3` when its color-pick bit is 1 (PIX_COLOR3), and as `overlay_color2` when it is 0 (PIX_COLOR2).
- R5: Within a row, cursor column 0 (pixel x equal to cursor x) uses bit 31, and column 31 uses bit 0.
- R6: Only pixel rows from cursor y to cursor y+31 are covered. Pixel row y uses plane row (y - cursor y).
- R7: No overlay is applied when the pixel x is at or beyond `line_width`, or when the cursor x is at or beyond `line_width`.
- R8: A write to offset 0x8FC sets the cursor x from data bits 31:16 and the cursor y from bits 15:0.
- R9: A write to offset 0x900+4r loads visibility row r. A write to offset 0x980+4r loads color-pick row r, for r from 0 to 31.
- R10: Offset 0x818 is read/write. A read returns the stored word with bit 25 forced to 1.
- R11: A read of any offset other than 0x818 returns zero, including the position and plane offsets. Writes to offsets outside the mapped ones change nothing.
- R12: `reg_rdata` shows the read result in the cycle after `reg_rd_en`, and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| line_width | input | 16 | Active line width in pixels |
| overlay_color2 | input | 24 | Color for visible bits with pick bit 0 |
| overlay_color3 | input | 24 | Color for visible bits with pick bit 1 |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x_i | input | 16 | Input pixel column |
| pix_y_i | input | 16 | Input pixel row |
| pix_data_i | input | 24 | Base pixel |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_data_o | output | 24 | Overlaid pixel |

## Verification
The hardest cases to reach from the ports are the exact edges of the cursor window. These are the first and last column, where the MSB-first bit order shows, and the first and last row. They are reached by placing the cursor at a known position and giving the edge rows asymmetric patterns, so that a swapped bit order or an off-by-one row lands on a different class. The reset position is confirmed by raising the line width to its maximum, so that a pixel at 0xF000,0xF000 falls inside the window. Ignored writes are checked by sending afterwards a pixel that the write would have altered.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int REG_ADDR_W = 12;
    localparam int REG_DATA_W = 32;
    localparam int COORD_W    = 16;
    localparam int PIX_W      = 24;
    localparam int CUR_SIZE   = 32;

    localparam logic [REG_ADDR_W-1:0] POS_OFS   = 12'h8FC;
    localparam logic [REG_ADDR_W-1:0] SPARE_OFS = 12'h818;
    localparam logic [REG_ADDR_W-1:0] VIS_OFS   = 12'h900;
    localparam logic [REG_ADDR_W-1:0] PICK_OFS  = 12'h980;
    localparam logic [REG_DATA_W-1:0] SPARE_FORCE = 32'h0200_0000;
    localparam logic [COORD_W-1:0]    POS_RESET   = 16'hF000;

    typedef enum logic [1:0] {
        PIX_PASS   = 2'd0,
        PIX_COLOR2 = 2'd1,
        PIX_COLOR3 = 2'd2
    } pix_class_e;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W,
    parameter int DATA_W = REG_DATA_W,
    parameter int CW     = COORD_W,
    parameter int ROWS   = CUR_SIZE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CW-1:0]     cur_x,
    output logic [CW-1:0]     cur_y,
    input  logic [$clog2(ROWS)-1:0] row_sel,
    output logic [DATA_W-1:0] vis_row,
    output logic [DATA_W-1:0] pick_row
);
    localparam int IDX_W   = $clog2(ROWS);
    localparam int ROW_LSB = 2;
    localparam int WIN_LSB = ROW_LSB + IDX_W;

    logic [DATA_W-1:0] vis_q  [ROWS];
    logic [DATA_W-1:0] pick_q [ROWS];
    logic [DATA_W-1:0] spare_q;
    logic [IDX_W-1:0]  row_addr;
    logic hit_pos, hit_spare, hit_vis, hit_pick;

    // Address decode: word offset for single registers, window for rows
    always_comb begin
        row_addr  = addr[WIN_LSB-1:ROW_LSB];
        hit_pos   = (addr[ADDR_W-1:ROW_LSB] == POS_OFS[ADDR_W-1:ROW_LSB]);
        hit_spare = (addr[ADDR_W-1:ROW_LSB] == SPARE_OFS[ADDR_W-1:ROW_LSB]);
        hit_vis   = (addr[ADDR_W-1:WIN_LSB] == VIS_OFS[ADDR_W-1:WIN_LSB]);
        hit_pick  = (addr[ADDR_W-1:WIN_LSB] == PICK_OFS[ADDR_W-1:WIN_LSB]);
    end

    // Position and spare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x   <= POS_RESET;
            cur_y   <= POS_RESET;
            spare_q <= '0;
        end else if (wr_en) begin
            if (hit_pos) begin
                cur_x <= wdata[DATA_W-1:DATA_W-CW];
                cur_y <= wdata[CW-1:0];
            end
            if (hit_spare) begin
                spare_q <= wdata;
            end
        end
    end

    // Plane rows, one register per row and plane
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vis_q[r]  <= '0;
                pick_q[r] <= '0;
            end else if (wr_en && (row_addr == IDX_W'(r))) begin
                if (hit_vis) begin
                    vis_q[r] <= wdata;
                end
                if (hit_pick) begin
                    pick_q[r] <= wdata;
                end
            end
        end
    end

    assign vis_row  = vis_q[row_sel];
    assign pick_row = pick_q[row_sel];

    // Registered read data: only the spare register is readable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en && hit_spare) begin
            rdata <= spare_q | SPARE_FORCE;
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
    import cursor_pkg::*;
#(
    parameter int CW     = COORD_W,
    parameter int DATA_W = REG_DATA_W,
    parameter int SIZE   = CUR_SIZE
) (
    input  logic [CW-1:0]     pix_x,
    input  logic [CW-1:0]     pix_y,
    input  logic [CW-1:0]     cur_x,
    input  logic [CW-1:0]     cur_y,
    input  logic [CW-1:0]     width,
    output logic [$clog2(SIZE)-1:0] row_sel,
    input  logic [DATA_W-1:0] vis_row,
    input  logic [DATA_W-1:0] pick_row,
    output pix_class_e        cls
);
    localparam int IDX_W = $clog2(SIZE);

    logic [CW:0]      dx, dy;
    logic             in_x, in_y, on_line;
    logic [IDX_W-1:0] bit_sel;

    always_comb begin
        // Differences with a borrow bit: borrow set means pixel before cursor
        dx      = {1'b0, pix_x} - {1'b0, cur_x};
        dy      = {1'b0, pix_y} - {1'b0, cur_y};
        in_x    = !dx[CW] && (dx < (CW+1)'(SIZE));
        in_y    = !dy[CW] && (dy < (CW+1)'(SIZE));
        on_line = (pix_x < width) && (cur_x < width);
        row_sel = dy[IDX_W-1:0];
        // Leftmost cursor column maps to the top bit of the row word
        bit_sel = ~dx[IDX_W-1:0];
        cls     = PIX_PASS;
        if (in_x && in_y && on_line && vis_row[bit_sel]) begin
            cls = pick_row[bit_sel] ? PIX_COLOR3 : PIX_COLOR2;
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic [COORD_W-1:0]    line_width,
    input  logic [PIX_W-1:0]      overlay_color2,
    input  logic [PIX_W-1:0]      overlay_color3,
    input  logic                  pix_valid_i,
    input  logic [COORD_W-1:0]    pix_x_i,
    input  logic [COORD_W-1:0]    pix_y_i,
    input  logic [PIX_W-1:0]      pix_data_i,
    output logic                  pix_valid_o,
    output logic [PIX_W-1:0]      pix_data_o
);
    localparam int IDX_W = $clog2(CUR_SIZE);

    logic [COORD_W-1:0]    cur_x, cur_y;
    logic [IDX_W-1:0]      row_sel;
    logic [REG_DATA_W-1:0] vis_row, pick_row;
    pix_class_e            cls;

    cursor_regs #(
        .ADDR_W (REG_ADDR_W),
        .DATA_W (REG_DATA_W),
        .CW     (COORD_W),
        .ROWS   (CUR_SIZE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .row_sel  (row_sel),
        .vis_row  (vis_row),
        .pick_row (pick_row)
    );

    cursor_hit #(
        .CW     (COORD_W),
        .DATA_W (REG_DATA_W),
        .SIZE   (CUR_SIZE)
    ) u_hit (
        .pix_x    (pix_x_i),
        .pix_y    (pix_y_i),
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .width    (line_width),
        .row_sel  (row_sel),
        .vis_row  (vis_row),
        .pick_row (pick_row),
        .cls      (cls)
    );

    // Output stage: one register, selected by the pixel class
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid_o <= 1'b0;
            pix_data_o  <= '0;
        end else begin
            pix_valid_o <= pix_valid_i;
            unique case (cls)
                PIX_PASS:   pix_data_o <= pix_data_i;
                PIX_COLOR2: pix_data_o <= overlay_color2;
                PIX_COLOR3: pix_data_o <= overlay_color3;
                default:    pix_data_o <= pix_data_i;
            endcase
        end
    end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
    import cursor_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_rd_en,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [REG_DATA_W-1:0] reg_rdata,
    input logic [COORD_W-1:0]    line_width,
    input logic [PIX_W-1:0]      overlay_color2,
    input logic [PIX_W-1:0]      overlay_color3,
    input logic                  pix_valid_i,
    input logic [COORD_W-1:0]    pix_x_i,
    input logic [PIX_W-1:0]      pix_data_i,
    input logic                  pix_valid_o,
    input logic [PIX_W-1:0]      pix_data_o
);
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> pix_valid_o);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !pix_valid_o);

    assert_out_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> (pix_data_o == $past(pix_data_i)
                      || pix_data_o == $past(overlay_color2)
                      || pix_data_o == $past(overlay_color3)));

    assert_clip_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && (pix_x_i >= line_width)) |=> (pix_data_o == $past(pix_data_i)));

    assert_spare_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && (reg_addr == SPARE_OFS)) |=> reg_rdata[25]);

    assert_rdata_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> (reg_rdata == '0));
endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_rd_en      (reg_rd_en),
    .reg_addr       (reg_addr),
    .reg_rdata      (reg_rdata),
    .line_width     (line_width),
    .overlay_color2 (overlay_color2),
    .overlay_color3 (overlay_color3),
    .pix_valid_i    (pix_valid_i),
    .pix_x_i        (pix_x_i),
    .pix_data_i     (pix_data_i),
    .pix_valid_o    (pix_valid_o),
    .pix_data_o     (pix_data_o)
);

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] C2 = 24'h112233;
    localparam logic [23:0] C3 = 24'hAABBCC;
    localparam int NVEC = 12;
    // {x, y, expected class: 0 pass, 2 color2, 3 color3}; cursor at (100,50)
    localparam logic [47:0] VEC [NVEC] = '{
        {16'd100, 16'd50, 16'd2},  // R5 column 0 -> bit 31
        {16'd101, 16'd50, 16'd3},  // R4 pick bit set
        {16'd102, 16'd50, 16'd0},  // R3 visibility bit clear
        {16'd131, 16'd50, 16'd3},  // R5 column 31 -> bit 0
        {16'd132, 16'd50, 16'd0},  // R3 right of window
        {16'd99,  16'd50, 16'd0},  // R3 left of window
        {16'd100, 16'd81, 16'd2},  // R6 last row
        {16'd100, 16'd82, 16'd0},  // R6 below window
        {16'd100, 16'd49, 16'd0},  // R6 above window
        {16'd115, 16'd55, 16'd2},  // R4 pick bit clear
        {16'd116, 16'd55, 16'd3},  // R4 pick bit set
        {16'd110, 16'd60, 16'd0}   // R3 empty row
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] line_width = 16'd640;
    logic        pix_valid_i = 1'b0;
    logic [15:0] pix_x_i = '0, pix_y_i = '0;
    logic [23:0] pix_data_i = '0;
    logic        pix_valid_o;
    logic [23:0] pix_data_o;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cursor_overlay u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_width(line_width), .overlay_color2(C2), .overlay_color3(C3),
        .pix_valid_i(pix_valid_i), .pix_x_i(pix_x_i), .pix_y_i(pix_y_i),
        .pix_data_i(pix_data_i), .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        check(req, reg_rdata, exp);
    endtask

    task automatic pix_check(input string req, input logic [15:0] x, input logic [15:0] y,
                             input logic [23:0] base, input logic [23:0] exp);
        pix_valid_i = 1'b1; pix_x_i = x; pix_y_i = y; pix_data_i = base;
        @(negedge clk);
        pix_valid_i = 1'b0;
        check({req, " valid"}, {31'd0, pix_valid_o}, 32'd1);
        check(req, {8'd0, pix_data_o}, {8'd0, exp});
    endtask

    function automatic logic [23:0] expect_pix(input logic [15:0] code, input logic [23:0] base);
        case (code)
            16'd2:   return C2;
            16'd3:   return C3;
            default: return base;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 valid_o", {31'd0, pix_valid_o}, 32'd0);
        check("R1 rdata", reg_rdata, 32'd0);
        rd_check("R1 spare reset", 12'h818, 32'h0200_0000);
        wr(12'h900, 32'hFFFF_FFFF);
        pix_check("R1 off-screen at origin", 16'd0, 16'd0, 24'h000001, 24'h000001);
        line_width = 16'hFFFF;
        pix_check("R1 reset position F000", 16'hF000, 16'hF000, 24'h000002, C2);
        line_width = 16'd640;

        // R8 R9: program position and planes
        wr(12'h8FC, {16'd100, 16'd50});
        wr(12'h900, 32'hC000_0001);
        wr(12'h980, 32'h4000_0001);
        wr(12'h914, 32'hFFFF_FFFF);
        wr(12'h994, 32'h0000_FFFF);
        wr(12'h97C, 32'h8000_0000);
        wr(12'h9FC, 32'h0000_0000);

        // Table walk: R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            logic [23:0] base;
            base = 24'h0A0000 + 24'(i);
            pix_check($sformatf("R3/R4/R5/R6 vec%0d", i), VEC[i][47:32], VEC[i][31:16],
                      base, expect_pix(VEC[i][15:0], base));
        end

        // R2: idle input gives idle output
        pix_valid_i = 1'b0;
        @(negedge clk);
        check("R2 idle", {31'd0, pix_valid_o}, 32'd0);

        // R10 R12: spare register
        wr(12'h818, 32'h0000_00A5);
        rd_check("R10 spare readback", 12'h818, 32'h0200_00A5);
        @(negedge clk);
        check("R12 rdata zero without read", reg_rdata, 32'd0);

        // R11: other reads return zero, unmapped writes ignored
        rd_check("R11 position read", 12'h8FC, 32'd0);
        rd_check("R11 plane read", 12'h900, 32'd0);
        wr(12'hA00, 32'hFFFF_FFFF);
        wr(12'h8F8, 32'h0000_0000);
        pix_check("R11 row 10 untouched", 16'd110, 16'd60, 24'h0B0000, 24'h0B0000);
        pix_check("R11 position untouched", 16'd100, 16'd50, 24'h0B0001, C2);

        // R7: clipping against line width
        line_width = 16'd110;
        pix_check("R7 inside width", 16'd101, 16'd50, 24'h0C0000, C3);
        pix_check("R7 beyond width", 16'd131, 16'd50, 24'h0C0001, 24'h0C0001);
        wr(12'h8FC, {16'd110, 16'd50});
        line_width = 16'd640;
        pix_check("R8 moved cursor", 16'd111, 16'd50, 24'h0C0002, C3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule